// File: doc/BRIEF.md
# Register-Controlled General-Purpose I/O Port

This block is a bank of up to 32 general-purpose pins controlled through a small word-addressed register bus. Software sets each pin's direction, the level it drives, whether it blinks, and whether its input is read inverted. Each pin leaves the block as a driven value plus an output enable, so the pad ring only has to combine the two.

Inputs pass through a two-stage synchronizer. The synchronized level is then combined with an XOR against a per-pin inversion mask. The result can be read at a fixed offset, and writes to that offset have no effect. A free-running divider produces one square wave that is shared by all pins. Any pin whose blink bit is set drives that wave instead of its stored level. Bus accesses take one cycle, and read data comes from a register.

Top module: `gpio_port`

## Requirements
- R1: After reset, every stored register reads 0. `pin_oe` is all ones, `pin_out` is all zeros and `bus_rdata` is 0.
- R2: The direction register is at byte offset 0x04. A direction bit of 1 makes the pin an input (`pin_oe` bit = 0). A bit of 0 makes it an output (`pin_oe` bit = 1). The change shows on `pin_oe` in the cycle after the write.
- R3: The output-level register is at byte offset 0x00. On a pin whose blink bit is 0, `pin_out` equals the stored bit from the cycle after the write.
- R4: The input view is at byte offset 0x10 and is read-only. Each of its bits equals the pin's level, delayed through two flops, XORed with the matching bit of the inversion register at byte offset 0x0C. An inversion bit of 1 inverts the reading. A new pin level first appears in a read that completes at the third rising edge after the level is applied.
- R5: The blink register is at byte offset 0x08. A pin whose blink bit is 1 drives a shared phase signal. The phase starts low after reset and toggles once every `BLINK_HALF` cycles, so all blinking pins are in step.
- R6: When a pin's blink bit is cleared, `pin_out` returns to that pin's stored output level in the cycle after the write.
- R7: A read (`bus_sel`=1, `bus_wr`=0) returns the addressed register on `bus_rdata` after the next rising edge. Every other cycle, `bus_rdata` is 0. Reads of offsets 0x14 to 0x1C return 0. Writes to 0x10 or to unmapped offsets change no register.
- R8: A write (`bus_sel`=1, `bus_wr`=1) to a stored register takes effect at that edge, and a later read returns the written value. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Access strobe for the current cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | PIN_COUNT | Asynchronous pin levels |
| pin_out | output | PIN_COUNT | Value driven toward each pin |
| pin_oe | output | PIN_COUNT | Output enable per pin, 1 = drive |

## Verification
The hardest behaviour to reach from the ports is the exact latency of the input path. Its end is a registered read, so the delay is visible only by chaining reads back to back around a pin change. The bench changes `pin_in` on the same cycle it issues a read and then issues two more consecutive reads. It expects the old value twice and the new value on the third.

Blink timing is checked by counting toggles over a window that is a whole number of periods, so the count does not depend on the starting phase. A behavioural model that is stepped on every clock also covers the phase in every cycle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int unsigned REG_W = 32;
   localparam logic [2:0] SLOT_DOUT  = 3'd0;
   localparam logic [2:0] SLOT_DIR   = 3'd1;
   localparam logic [2:0] SLOT_BLINK = 3'd2;
   localparam logic [2:0] SLOT_POL   = 3'd3;
   localparam logic [2:0] SLOT_DIN   = 3'd4;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int unsigned PIN_COUNT = 32,
   parameter int unsigned ADDR_W    = 5
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 sel,
   input  logic                 wr,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [REG_W-1:0]     wdata,
   input  logic [PIN_COUNT-1:0] din_view,
   output logic [PIN_COUNT-1:0] dout_q,
   output logic [PIN_COUNT-1:0] dir_q,
   output logic [PIN_COUNT-1:0] blink_q,
   output logic [PIN_COUNT-1:0] pol_q,
   output logic [REG_W-1:0]     rdata_q
);
   logic                 in_range;
   logic [2:0]           slot;
   logic                 wr_en;
   logic                 rd_en;
   logic [PIN_COUNT-1:0] rd_mux;

   generate
      if (ADDR_W > 5) begin : g_upper_decode
         assign in_range = (addr[ADDR_W-1:5] == '0);
      end else begin : g_no_upper
         assign in_range = 1'b1;
      end
   endgenerate

   assign slot  = addr[4:2];
   assign wr_en = sel & wr & in_range;
   assign rd_en = sel & ~wr & in_range;

   always_ff @(posedge clk) begin
      if (rst) begin
         dout_q  <= '0;
         dir_q   <= '0;
         blink_q <= '0;
         pol_q   <= '0;
      end else if (wr_en) begin
         case (slot)
            SLOT_DOUT:  dout_q  <= wdata[PIN_COUNT-1:0];
            SLOT_DIR:   dir_q   <= wdata[PIN_COUNT-1:0];
            SLOT_BLINK: blink_q <= wdata[PIN_COUNT-1:0];
            SLOT_POL:   pol_q   <= wdata[PIN_COUNT-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (slot)
         SLOT_DOUT:  rd_mux = dout_q;
         SLOT_DIR:   rd_mux = dir_q;
         SLOT_BLINK: rd_mux = blink_q;
         SLOT_POL:   rd_mux = pol_q;
         SLOT_DIN:   rd_mux = din_view;
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)        rdata_q <= '0;
      else if (rd_en) rdata_q <= REG_W'(rd_mux);
      else            rdata_q <= '0;
   end

   // R7: a write aimed at the input view leaves every stored register untouched
   assert_din_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
      (wr_en && slot == SLOT_DIN) |=>
         ($stable(dout_q) && $stable(dir_q) && $stable(blink_q) && $stable(pol_q)));

   // R7: read data is zero in any cycle not preceded by a read
   assert_idle_rdata_zero_R7: assert property (@(posedge clk) disable iff (rst)
      !(sel && !wr) |=> (rdata_q == '0));

   // R8: a write to the inversion register lands at that edge
   assert_pol_write_lands_R8: assert property (@(posedge clk) disable iff (rst)
      (wr_en && slot == SLOT_POL) |=> (pol_q == $past(wdata[PIN_COUNT-1:0])));
endmodule

// File: rtl/gpio_port_insync.sv
module gpio_port_insync #(
   parameter int unsigned PIN_COUNT = 32,
   parameter int unsigned STAGES    = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [PIN_COUNT-1:0] pin_in,
   input  logic [PIN_COUNT-1:0] pol,
   output logic [PIN_COUNT-1:0] din_view
);
   logic [PIN_COUNT-1:0] stage_q [STAGES];
   logic                 up_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_port_insync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else if (s == 0) stage_q[s] <= pin_in;
            else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign din_view = stage_q[STAGES-1] ^ pol;

   always_ff @(posedge clk) begin
      if (rst) up_q <= 1'b0;
      else     up_q <= 1'b1;
   end

   // R4: the final stage carries the previous stage one cycle later
   assert_sync_shift_R4: assert property (@(posedge clk) disable iff (rst)
      up_q |-> (stage_q[STAGES-1] == $past(stage_q[STAGES-2])));
endmodule

// File: rtl/gpio_port_blink.sv
module gpio_port_blink #(
   parameter int unsigned BLINK_HALF = 25_000_000
) (
   input  logic clk,
   input  logic rst,
   output logic phase_q
);
   localparam int unsigned CNT_W = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;

   generate
      if (BLINK_HALF < 1) begin : g_bad_half
         $error("gpio_port_blink: BLINK_HALF must be at least 1");
      end
      if (BLINK_HALF == 1) begin : g_every_cycle
         always_ff @(posedge clk) begin
            if (rst) phase_q <= 1'b0;
            else     phase_q <= ~phase_q;
         end
      end else begin : g_divided
         logic [CNT_W-1:0] cnt_q;
         logic             up_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               cnt_q   <= '0;
               phase_q <= 1'b0;
               up_q    <= 1'b0;
            end else begin
               up_q <= 1'b1;
               if (cnt_q == CNT_W'(BLINK_HALF-1)) begin
                  cnt_q   <= '0;
                  phase_q <= ~phase_q;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end

         // R5: the phase moves only when the divider wraps
         assert_blink_period_R5: assert property (@(posedge clk) disable iff (rst)
            (up_q && phase_q != $past(phase_q)) |-> ($past(cnt_q) == CNT_W'(BLINK_HALF-1)));
      end
   endgenerate
endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_port_pkg::*;
#(
   parameter int unsigned PIN_COUNT  = 32,
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned BLINK_HALF = 25_000_000,
   parameter int unsigned SYNC_DEPTH = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   input  logic [PIN_COUNT-1:0] pin_in,
   output logic [PIN_COUNT-1:0] pin_out,
   output logic [PIN_COUNT-1:0] pin_oe
);
   localparam logic [ADDR_W-1:0] DIR_ADDR   = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] BLINK_ADDR = ADDR_W'(8);

   generate
      if (PIN_COUNT < 1 || PIN_COUNT > REG_W) begin : g_bad_pins
         $error("gpio_port: PIN_COUNT must be 1..32");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("gpio_port: ADDR_W must be at least 5");
      end
   endgenerate

   logic [PIN_COUNT-1:0] dout_q, dir_q, blink_q, pol_q, din_view;
   logic                 phase;

   gpio_port_regs #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) regs_i (
      .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .din_view(din_view), .dout_q(dout_q), .dir_q(dir_q),
      .blink_q(blink_q), .pol_q(pol_q), .rdata_q(bus_rdata)
   );

   gpio_port_insync #(.PIN_COUNT(PIN_COUNT), .STAGES(SYNC_DEPTH)) sync_i (
      .clk(clk), .rst(rst), .pin_in(pin_in), .pol(pol_q), .din_view(din_view)
   );

   gpio_port_blink #(.BLINK_HALF(BLINK_HALF)) blink_i (
      .clk(clk), .rst(rst), .phase_q(phase)
   );

   generate
      for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
         assign pin_out[p] = blink_q[p] ? phase : dout_q[p];
         assign pin_oe[p]  = ~dir_q[p];
      end
   endgenerate

   // R2: a direction write shows up inverted on the enables next cycle
   assert_oe_follows_dir_R2: assert property (@(posedge clk) disable iff (rst)
      (bus_sel && bus_wr && bus_addr == DIR_ADDR) |=>
         (pin_oe == ~$past(bus_wdata[PIN_COUNT-1:0])));

   // R6: clearing all blink bits hands every pin back to its stored level
   assert_unblink_restores_R6: assert property (@(posedge clk) disable iff (rst)
      (bus_sel && bus_wr && bus_addr == BLINK_ADDR && bus_wdata == '0) |=>
         (pin_out == dout_q));
endmodule

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
   localparam int HALF = 5;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out;
   logic [31:0] pin_oe;

   int vectors = 0;
   int miscompares = 0;
   bit started = 1'b0;

   always #2.5 clk = ~clk;

   gpio_port #(.PIN_COUNT(32), .ADDR_W(5), .BLINK_HALF(HALF), .SYNC_DEPTH(2)) dut_i (
      .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   // behavioural reference model
   logic [31:0] m_dout, m_dir, m_blink, m_pol, m_s1, m_s2, m_rdata;
   int          m_cnt;
   logic        m_phase;

   always @(posedge clk) begin : model
      logic [31:0] view;
      if (rst) begin
         m_dout = 0; m_dir = 0; m_blink = 0; m_pol = 0;
         m_s1 = 0; m_s2 = 0; m_rdata = 0; m_cnt = 0; m_phase = 0;
      end else begin
         view = m_s2 ^ m_pol;
         m_rdata = 0;
         if (bus_sel && !bus_wr) begin
            case (bus_addr[4:2])
               3'd0: m_rdata = m_dout;
               3'd1: m_rdata = m_dir;
               3'd2: m_rdata = m_blink;
               3'd3: m_rdata = m_pol;
               3'd4: m_rdata = view;
               default: m_rdata = 0;
            endcase
         end
         if (bus_sel && bus_wr) begin
            case (bus_addr[4:2])
               3'd0: m_dout = bus_wdata;
               3'd1: m_dir = bus_wdata;
               3'd2: m_blink = bus_wdata;
               3'd3: m_pol = bus_wdata;
               default: ;
            endcase
         end
         m_s2 = m_s1;
         m_s1 = pin_in;
         if (m_cnt == HALF-1) begin
            m_cnt = 0;
            m_phase = ~m_phase;
         end else begin
            m_cnt++;
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare against the model on every clock
   always @(negedge clk) begin
      if (started && !rst) begin
         check("R5 pin_out vs model", pin_out, (m_blink & {32{m_phase}}) | (~m_blink & m_dout));
         check("R2 pin_oe vs model", pin_oe, ~m_dir);
         check("R7 bus_rdata vs model", bus_rdata, m_rdata);
      end
   end

   task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog (every requirement) act=running exp=finished");
      summary();
   end

   initial begin : stim
      logic [31:0] r;
      int          toggles;
      logic        prev;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      started = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 pin_oe after reset", pin_oe, 32'hFFFF_FFFF);
      check("R1 pin_out after reset", pin_out, 32'h0);
      check("R1 rdata idle after reset", bus_rdata, 32'h0);
      for (int k = 0; k < 5; k++) begin
         bus_read(5'(k*4), r);
         check("R1 register reads zero", r, 32'h0);
      end

      // R3 / R8 output level
      bus_write(5'h00, 32'hA5A5_F00F);
      check("R3 pin_out follows stored level", pin_out, 32'hA5A5_F00F);
      bus_read(5'h01, r);
      check("R8 readback with low address bits set", r, 32'hA5A5_F00F);

      // R2 direction
      bus_write(5'h04, 32'hFFFF_0000);
      check("R2 pin_oe after direction write", pin_oe, 32'h0000_FFFF);
      bus_read(5'h04, r);
      check("R8 direction readback", r, 32'hFFFF_0000);

      // R4 input path and inversion
      pin_in = 32'h1234_5678;
      repeat (3) @(negedge clk);
      bus_read(5'h10, r);
      check("R4 input view plain", r, 32'h1234_5678);
      bus_write(5'h0C, 32'hFFFF_0000);
      bus_read(5'h10, r);
      check("R4 input view inverted upper half", r, 32'hEDCB_5678);
      bus_write(5'h0C, 32'h0);
      pin_in = 32'h0F0F_0F0F;
      bus_read(5'h10, r);
      check("R4 latency first read old", r, 32'h1234_5678);
      bus_read(5'h10, r);
      check("R4 latency second read old", r, 32'h1234_5678);
      bus_read(5'h10, r);
      check("R4 latency third read new", r, 32'h0F0F_0F0F);

      // R7 ignored writes and unmapped reads
      bus_write(5'h10, 32'hDEAD_BEEF);
      bus_write(5'h14, 32'hDEAD_BEEF);
      bus_read(5'h00, r);
      check("R7 stored level untouched", r, 32'hA5A5_F00F);
      bus_read(5'h04, r);
      check("R7 direction untouched", r, 32'hFFFF_0000);
      bus_read(5'h08, r);
      check("R7 blink untouched", r, 32'h0);
      bus_read(5'h0C, r);
      check("R7 inversion untouched", r, 32'h0);
      bus_read(5'h18, r);
      check("R7 unmapped reads zero", r, 32'h0);
      @(negedge clk);
      check("R7 idle rdata zero", bus_rdata, 32'h0);

      // R5 blink
      bus_write(5'h00, 32'h0000_0000);
      bus_write(5'h04, 32'h0000_0000);
      bus_write(5'h08, 32'h0000_00F0);
      prev = pin_out[4];
      toggles = 0;
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         if (pin_out[4] != prev) toggles++;
         prev = pin_out[4];
         check("R5 blinking pins in step", {28'h0, pin_out[7:4]}, pin_out[4] ? 32'hF : 32'h0);
      end
      check("R5 toggle count over 40 cycles", 32'(toggles), 32'd8);

      // R6 clear blink
      bus_write(5'h00, 32'h0000_00A0);
      bus_write(5'h08, 32'h0);
      check("R6 pins back to stored level", pin_out, 32'h0000_00A0);
      repeat (12) @(negedge clk);
      check("R6 stays steady", pin_out, 32'h0000_00A0);

      summary();
   end
endmodule